// File: doc/BRIEF.md
# Latest-Value Word Fan-Out Across Clock Domains

This block carries one data word from a single write clock domain to a configurable number of read clock domains, each running on its own clock that bears no relation to the others. Each reader keeps the most recent word it has received and raises a one-cycle pulse whenever a fresh word lands. Every read domain gets its own toggle request/acknowledge handshake, so a slow reader never holds back a fast one.

The whole word crosses as a unit. The write side parks the word in a per-reader holding register that stays frozen while the request toggle crosses over. The reader copies the register only after its synchronised request shows a change. If the writer strobes faster than a reader's handshake can turn around, the words in between are dropped. A pending register keeps only the newest of them, so each reader always ends on the last word written.

Each domain has its own synchronous, active-high reset. A reader can be held in reset while the others keep receiving. Once released, it catches up to the latest word.

Top module: `cdc_word_fanout`

## Requirements
- R1: While a reader's reset is asserted, and after it until that reader's first delivery, its `rd_data` slice is all zeros and its `rd_new` bit is 0.
- R2: `rd_new[i]` is a single-cycle pulse: it is never high in two consecutive cycles of `rd_clk[i]`.
- R3: A reader's `rd_data` slice changes only in a cycle in which its `rd_new` bit is high.
- R4: Every word a reader presents with `rd_new` equals, in all bits, a word supplied on `wr_data` in one single write-strobe cycle (no torn words).
- R5: A single write made while every lane is idle is delivered exactly once to every reader, with the exact value written.
- R6: A lane starts a new transfer (toggles its request) only when its synchronised acknowledge equals its request.
- R7: A lane's holding register does not change while that lane's transfer is in flight.
- R8: When writes arrive faster than the handshake completes, the intermediate words may be dropped, but each reader ends on the last word written, and gets no more deliveries than there were writes. A word left pending is launched in the first cycle the lane is idle.
- R9: A reader held in reset does not stop the other readers from receiving. After its release, it converges to the last word written.
- R10: With `wr_en` held at 0, no reader produces any further `rd_new` pulse once the outstanding transfers have finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst | input | 1 | Write domain synchronous reset, active high |
| wr_en | input | 1 | Write strobe: `wr_data` is a new word this cycle |
| wr_data | input | DATA_W | Word to publish |
| rd_clk | input | N_RD | One clock per read domain (bit i is reader i) |
| rd_rst | input | N_RD | Per-reader synchronous reset, active high |
| rd_data | output | N_RD*DATA_W | Reader i's latest word in bits [i*DATA_W +: DATA_W] |
| rd_new | output | N_RD | Bit i pulses for one `rd_clk[i]` cycle when reader i takes a word |

## Verification
Two events on the write side can fall in the same cycle: a fresh write strobe, and the returning acknowledge that makes a lane idle while an older word is still pending. In that cycle the fresh word must win and the pending one must be discarded. The bench provokes the collision by sweeping the gap between writes from zero to twelve write cycles, against three readers with unrelated periods, so writes land at every phase of each handshake. It judges the outcome in two ways: each reader must settle on the final word, and every delivered word must carry its self-check pattern (upper byte the inverse of the lower byte), which shows it is untorn.

// File: rtl/cdc_fanout_pkg.sv
package cdc_fanout_pkg;

  typedef enum logic {LANE_IDLE = 1'b0, LANE_BUSY = 1'b1} lane_state_e;

  // A lane is idle once the returned acknowledge has caught up with the request.
  function automatic lane_state_e lane_state(input logic req, input logic ack);
    return (req == ack) ? LANE_IDLE : LANE_BUSY;
  endfunction

  // A toggle event is seen when the synchronised level differs from the last one taken.
  function automatic logic toggle_event(input logic now_lvl, input logic seen_lvl);
    return now_lvl ^ seen_lvl;
  endfunction

endpackage

// File: rtl/fanout_sync.sv
module fanout_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fanout_tx_lane.sv
module fanout_tx_lane
  import cdc_fanout_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ack_tgl,
  output logic              req_tgl,
  output logic [DATA_W-1:0] hold_data
);
  logic              ack_s;
  logic              req_q;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] pend_q;
  logic              pend_vld;
  logic              idle;
  logic              launch;
  logic [DATA_W-1:0] launch_data;

  fanout_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(wr_clk), .rst(wr_rst), .d(ack_tgl), .q(ack_s)
  );

  assign idle        = (lane_state(req_q, ack_s) == LANE_IDLE);
  assign launch      = idle && (wr_en || pend_vld);
  assign launch_data = wr_en ? wr_data : pend_q;

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      req_q    <= 1'b0;
      hold_q   <= '0;
      pend_q   <= '0;
      pend_vld <= 1'b0;
    end else if (launch) begin
      hold_q   <= launch_data;
      req_q    <= ~req_q;
      pend_vld <= 1'b0;
    end else if (wr_en) begin
      pend_q   <= wr_data;
      pend_vld <= 1'b1;
    end
  end

  assign req_tgl   = req_q;
  assign hold_data = hold_q;

  // R6: request toggles only out of an idle lane
  p_launch_when_idle_r6: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !idle |=> $stable(req_q));
  // R7: holding word frozen while transfer in flight
  p_hold_stable_r7: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !idle |=> $stable(hold_q));
  // R8: a pending word is launched as soon as the lane is idle
  p_pending_launch_r8: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (idle && pend_vld) |=> (req_q != $past(req_q)));
endmodule

// File: rtl/fanout_rx_lane.sv
module fanout_rx_lane
  import cdc_fanout_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              req_tgl,
  input  logic [DATA_W-1:0] hold_data,
  output logic              ack_tgl,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_new
);
  logic              req_s;
  logic              ack_q;
  logic [DATA_W-1:0] data_q;
  logic              new_q;
  logic              capture;

  fanout_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(rd_clk), .rst(rd_rst), .d(req_tgl), .q(req_s)
  );

  assign capture = toggle_event(req_s, ack_q);

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      ack_q  <= 1'b0;
      data_q <= '0;
      new_q  <= 1'b0;
    end else begin
      new_q <= capture;
      if (capture) begin
        data_q <= hold_data;
        ack_q  <= req_s;
      end
    end
  end

  assign ack_tgl = ack_q;
  assign rd_data = data_q;
  assign rd_new  = new_q;

  // R2: new-value flag is a one-cycle pulse
  p_new_single_r2: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_new |=> !rd_new);
  // R3: output word moves only together with the pulse
  p_data_hold_r3: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !rd_new |-> $stable(rd_data));
endmodule

// File: rtl/cdc_word_fanout.sv
module cdc_word_fanout #(
  parameter int DATA_W      = 16,
  parameter int N_RD        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     wr_clk,
  input  logic                     wr_rst,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [N_RD-1:0]          rd_clk,
  input  logic [N_RD-1:0]          rd_rst,
  output logic [N_RD*DATA_W-1:0]   rd_data,
  output logic [N_RD-1:0]          rd_new
);
  logic [N_RD-1:0]   req_tgl;
  logic [N_RD-1:0]   ack_tgl;
  logic [DATA_W-1:0] hold_data [N_RD];

  for (genvar gi = 0; gi < N_RD; gi++) begin : g_lane
    fanout_tx_lane #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_tx (
      .wr_clk   (wr_clk),
      .wr_rst   (wr_rst),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .ack_tgl  (ack_tgl[gi]),
      .req_tgl  (req_tgl[gi]),
      .hold_data(hold_data[gi])
    );

    fanout_rx_lane #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .rd_clk   (rd_clk[gi]),
      .rd_rst   (rd_rst[gi]),
      .req_tgl  (req_tgl[gi]),
      .hold_data(hold_data[gi]),
      .ack_tgl  (ack_tgl[gi]),
      .rd_data  (rd_data[gi*DATA_W +: DATA_W]),
      .rd_new   (rd_new[gi])
    );
  end
endmodule

// File: tb/cdc_word_fanout_bench.sv
`timescale 1ns/1ps
module cdc_word_fanout_bench;
  localparam int DW = 16;
  localparam int NR = 3;

  logic          wr_clk = 1'b0;
  logic          wr_rst = 1'b1;
  logic          wr_en  = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          c0 = 1'b0, c1 = 1'b0, c2 = 1'b0;
  logic [NR-1:0] rd_clk;
  logic [NR-1:0] rd_rst = '1;
  logic [NR*DW-1:0] rd_data;
  logic [NR-1:0] rd_new;

  assign rd_clk = {c2, c1, c0};

  always #2.5 wr_clk = ~wr_clk;
  always #3.3 c0 = ~c0;
  always #1.7 c1 = ~c1;
  always #5.1 c2 = ~c2;

  cdc_word_fanout #(.DATA_W(DW), .N_RD(NR)) u_cdc_word_fanout (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_data(rd_data), .rd_new(rd_new)
  );

  int checks = 0;
  int errors = 0;
  int last_k = 0;
  bit done = 0;

  logic [31:0] pulses_a [NR];
  logic [31:0] mchk_a   [NR];
  logic [31:0] merr_a   [NR];

  function automatic logic [DW-1:0] enc(input int k);
    logic [7:0] lo;
    lo = k[7:0];
    return {~lo, lo};
  endfunction

  function automatic logic [DW-1:0] rd_word(input int i);
    return rd_data[i*DW +: DW];
  endfunction

  // Per-reader monitors, sampling on the reader's own falling edge.
  for (genvar gi = 0; gi < NR; gi++) begin : g_mon
    logic [31:0]   pulses = 0;
    logic [31:0]   mchk = 0;
    logic [31:0]   merr = 0;
    logic [DW-1:0] prev_d = '0;
    logic          prev_n = 1'b0;
    assign pulses_a[gi] = pulses;
    assign mchk_a[gi]   = mchk;
    assign merr_a[gi]   = merr;

    always @(negedge rd_clk[gi]) begin
      if (!rd_rst[gi]) begin
        if (rd_new[gi]) begin
          pulses <= pulses + 1;
          mchk   <= mchk + 1;
          if (rd_data[gi*DW+8 +: 8] != ~rd_data[gi*DW +: 8]) begin
            merr <= merr + 1;
            $display("FAIL R4 reader %0d torn word: actual %h expected {~lo,lo}", gi, rd_data[gi*DW +: DW]);
          end
          if (prev_n) begin
            merr <= merr + 1;
            $display("FAIL R2 reader %0d pulse wider than one cycle: actual 1 expected 0", gi);
          end
        end else if (rd_data[gi*DW +: DW] != prev_d) begin
          merr <= merr + 1;
          $display("FAIL R3 reader %0d data moved without pulse: actual %h expected %h",
                   gi, rd_data[gi*DW +: DW], prev_d);
        end
      end
      prev_d <= rd_data[gi*DW +: DW];
      prev_n <= rd_new[gi];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input int k, input int gap);
    @(negedge wr_clk);
    wr_en   = 1'b1;
    wr_data = enc(k);
    last_k  = k;
    @(negedge wr_clk);
    wr_en = 1'b0;
    for (int g = 0; g < gap; g++) @(negedge wr_clk);
  endtask

  task automatic settle(input int ns);
    #(ns);
    @(negedge wr_clk);
  endtask

  task automatic summary();
    int tc;
    int te;
    tc = checks;
    te = errors;
    for (int i = 0; i < NR; i++) begin
      tc += int'(mchk_a[i]);
      te += int'(merr_a[i]);
    end
    $display("Simulation finished: %0d checks, %0d errors", tc, te);
  endtask

  initial begin
    #100us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] p0 [NR];
    int k;
    // Reset, held across several edges of the slowest reader.
    repeat (30) @(negedge wr_clk);
    wr_rst = 1'b0;
    rd_rst = '0;
    @(negedge wr_clk);
    for (int i = 0; i < NR; i++) begin
      chk(rd_word(i) == '0, "R1 data zero after reset", rd_word(i), 0);
      chk(rd_new[i] == 1'b0, "R1 no pulse after reset", rd_new[i], 0);
    end
    settle(80);
    for (int i = 0; i < NR; i++)
      chk(pulses_a[i] == 0 && rd_word(i) == '0, "R10 quiet after reset", pulses_a[i], 0);

    // R5: single isolated write, exactly one delivery per reader.
    wr_word(1, 0);
    settle(300);
    for (int i = 0; i < NR; i++) begin
      chk(rd_word(i) == enc(1), "R5 isolated value", rd_word(i), enc(1));
      chk(pulses_a[i] == 1, "R5 delivered once", pulses_a[i], 1);
    end

    // R8: burst of back-to-back writes.
    for (int i = 0; i < NR; i++) p0[i] = pulses_a[i];
    for (int j = 2; j <= 41; j++) wr_word(j, 0);
    settle(500);
    for (int i = 0; i < NR; i++) begin
      chk(rd_word(i) == enc(41), "R8 burst final value", rd_word(i), enc(41));
      chk((pulses_a[i] - p0[i]) >= 1 && (pulses_a[i] - p0[i]) <= 40,
          "R8 burst delivery count", pulses_a[i] - p0[i], 40);
      p0[i] = pulses_a[i];
    end
    settle(300);
    for (int i = 0; i < NR; i++)
      chk(pulses_a[i] == p0[i], "R10 no pulses while idle", pulses_a[i], p0[i]);

    // R8 sweep: write spacing 0..12 write cycles hits every handshake phase.
    k = 42;
    for (int gap = 0; gap <= 12; gap++) begin
      for (int n = 0; n < 6; n++) begin
        wr_word(k, gap);
        k++;
      end
      settle(400);
      for (int i = 0; i < NR; i++)
        chk(rd_word(i) == enc(last_k), "R8 sweep final value", rd_word(i), enc(last_k));
    end

    // R9: reader 1 held in reset while writes continue.
    rd_rst[1] = 1'b1;
    settle(60);
    for (int n = 0; n < 5; n++) begin
      wr_word(k, 3);
      k++;
    end
    settle(400);
    chk(rd_word(0) == enc(last_k), "R9 reader 0 unaffected", rd_word(0), enc(last_k));
    chk(rd_word(2) == enc(last_k), "R9 reader 2 unaffected", rd_word(2), enc(last_k));
    chk(rd_word(1) == '0 && rd_new[1] == 1'b0, "R1 reader 1 zero in reset", rd_word(1), 0);
    rd_rst[1] = 1'b0;
    settle(400);
    chk(rd_word(1) == enc(last_k), "R9 reader 1 catches up", rd_word(1), enc(last_k));
    for (int i = 0; i < NR; i++) p0[i] = pulses_a[i];
    settle(300);
    for (int i = 0; i < NR; i++)
      chk(pulses_a[i] == p0[i], "R10 quiet after catch-up", pulses_a[i], p0[i]);

    done = 1;
    summary();
    $finish;
  end
endmodule